// File: doc/BRIEF.md
# UART Transmit Character Buffer with Data Request

This block sits between a processor's write port and a UART's transmit shift register. Software writes characters one per cycle with a write strobe. The block holds them and offers them in arrival order to the shifter over a valid/ready handshake. It runs in one of two modes. In holding mode a single character is held. In FIFO mode up to 64 characters are held.

From its fill level the block keeps a registered transmit data request flag. In FIFO mode the flag goes high once the buffer is half empty. In holding mode it goes high when the single slot is free. The flag drives an interrupt output and a DMA request output, each gated by its own enable. A transmitter-empty status combines the buffer state with a busy input from the shifter. A flush pulse empties the buffer. A change of mode also empties it.

Back-pressure: the write side has none. A write strobe is taken in only if there is room, and otherwise the character is lost without notice. On the output side a character leaves only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_data` holds still while `tx_valid` is high and `tx_ready` is low. A high `tx_ready` while `tx_valid` is low does nothing.

Top module: `uart_tx_buffer`

## Requirements
- R1: In FIFO mode the buffer holds 64 characters. A write that arrives while 64 are held, in a cycle with no load from the shifter, is dropped and raises no error.
- R2: In FIFO mode `tx_req` is 1 while the buffer holds 32 characters or fewer and 0 while it holds 33 or more. The flag shows the level reached at a clock edge from the cycle that follows that edge.
- R3: A high `fifo_reset` at a clock edge empties the buffer and drops any write in the same cycle. After that edge `tx_valid` is 0 and `tx_req` is 1.
- R4: In holding mode (`fifo_mode`=0) there is a single slot. A write clears `tx_req`. A load by the shifter sets `tx_req`. A write while the slot is occupied is dropped.
- R5: `tx_irq` equals `tx_req` AND `irq_en`.
- R6: `tx_dma_req` equals `tx_req` AND `dma_en` AND `fifo_mode`, so it stays 0 in holding mode.
- R7: After reset `tx_req` is 1, `tx_valid` is 0 and the block is in holding mode. With `shift_busy` low, `tx_empty` is also 1.
- R8: `tx_empty` is 1 exactly when the buffer is empty and `shift_busy` is 0.
- R9: Characters leave in write order, one per cycle in which `tx_valid` and `tx_ready` are both high. `tx_ready` while the buffer is empty has no effect.
- R10: A write and a load in the same cycle are both accepted at any level, including when the buffer is full. The level stays unchanged.
- R11: A change of `fifo_mode` empties the buffer at that edge. After that edge `tx_valid` is 0 and `tx_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 8 | Character written |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = holding mode |
| fifo_reset | input | 1 | Flush pulse for the transmit buffer |
| irq_en | input | 1 | Enables the interrupt from the data request |
| dma_en | input | 1 | Enables the DMA request |
| shift_busy | input | 1 | Shift register is still sending a character |
| tx_valid | output | 1 | A character is offered to the shifter |
| tx_data | output | 8 | Oldest held character |
| tx_ready | input | 1 | Shifter loads the offered character |
| tx_req | output | 1 | Transmit data request flag |
| tx_irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | DMA request |
| tx_empty | output | 1 | Buffer and shift register both empty |

## Verification
A wrong occupancy count shows up at the ports within one cycle. `tx_req` flips at the wrong level, or `tx_valid` disagrees with what has been written and loaded. A fault in the pointers or storage shows up as a wrong or out-of-order character. It is seen at the first load that reaches the bad entry, which in the drain after a full fill is at most 64 cycles later. Dropped writes are seen by counting the characters that come out. A flush or mode change that fails to clear the buffer shows up at once as `tx_valid` staying high.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;
  localparam int unsigned TXB_CHAR_W = 8;
  localparam int unsigned TXB_DEPTH  = 64;

  typedef enum logic {
    TXB_MODE_HOLD = 1'b0,
    TXB_MODE_FIFO = 1'b1
  } txb_mode_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } txb_ctl_t;
endpackage

// File: rtl/uart_txb_level.sv
module uart_txb_level
  import uart_txb_pkg::*;
#(
  parameter int unsigned DEPTH = TXB_DEPTH,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_rdy,
  input  txb_mode_e     mode,
  input  logic          flush,
  output txb_ctl_t      ctl,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt
);
  localparam logic [CW-1:0] CAP_FIFO = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_HOLD = CW'(1);

  logic [CW-1:0] cap;
  logic          room;

  always_comb begin
    cap       = (mode == TXB_MODE_FIFO) ? CAP_FIFO : CAP_HOLD;
    room      = (count < cap);
    ctl.flush = flush;
    ctl.pop   = rd_rdy && (count != '0) && !flush;
    ctl.push  = wr_en && !flush && (room || ctl.pop);
    if (flush)
      count_nxt = '0;
    else if (ctl.push && !ctl.pop)
      count_nxt = count + CW'(1);
    else if (ctl.pop && !ctl.push)
      count_nxt = count - CW'(1);
    else
      count_nxt = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP_FIFO); // R1
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && rd_rdy && !wr_en) |=> (count == '0)); // R9
  AST_SAME_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.push && ctl.pop) |=> (count == $past(count))); // R10
endmodule

// File: rtl/uart_txb_store.sv
module uart_txb_store
  import uart_txb_pkg::*;
#(
  parameter int unsigned DEPTH = TXB_DEPTH,
  parameter int unsigned W     = TXB_CHAR_W,
  parameter int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  txb_ctl_t     ctl,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  localparam bit POW2 = ((1 << AW) == DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] wr_inc, rd_inc;

  generate
    if (POW2) begin : g_wrap_free
      always_comb begin
        wr_inc = wr_ptr + AW'(1);
        rd_inc = rd_ptr + AW'(1);
      end
    end else begin : g_wrap_cmp
      always_comb begin
        wr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
        rd_inc = (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (ctl.flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (ctl.push) wr_ptr <= wr_inc;
      if (ctl.pop)  rd_ptr <= rd_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  AST_FLUSH_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flush |=> (wr_ptr == rd_ptr)); // R3
endmodule

// File: rtl/uart_txb_req.sv
module uart_txb_req
  import uart_txb_pkg::*;
#(
  parameter int unsigned DEPTH = TXB_DEPTH,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_nxt,
  input  txb_mode_e     mode,
  input  logic          irq_en,
  input  logic          dma_en,
  output logic          tx_req,
  output logic          tx_irq,
  output logic          tx_dma_req
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic req_d;

  always_comb begin
    if (mode == TXB_MODE_FIFO) req_d = (count_nxt <= HALF);
    else                       req_d = (count_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_req <= 1'b1;
    else        tx_req <= req_d;
  end

  assign tx_irq     = tx_req && irq_en;
  assign tx_dma_req = tx_req && dma_en && (mode == TXB_MODE_FIFO);

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (irq_en && tx_req)); // R5
  AST_DMA_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> (mode == TXB_MODE_FIFO)); // R6
endmodule

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer
  import uart_txb_pkg::*;
#(
  parameter int unsigned DEPTH = TXB_DEPTH,
  parameter int unsigned W     = TXB_CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         fifo_mode,
  input  logic         fifo_reset,
  input  logic         irq_en,
  input  logic         dma_en,
  input  logic         shift_busy,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  input  logic         tx_ready,
  output logic         tx_req,
  output logic         tx_irq,
  output logic         tx_dma_req,
  output logic         tx_empty
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  txb_mode_e     mode, mode_q;
  logic          flush;
  txb_ctl_t      ctl;
  logic [CW-1:0] count, count_nxt;

  assign mode = fifo_mode ? TXB_MODE_FIFO : TXB_MODE_HOLD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= TXB_MODE_HOLD;
    else        mode_q <= mode;
  end

  assign flush = fifo_reset || (mode != mode_q);

  uart_txb_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_rdy    (tx_ready),
    .mode      (mode),
    .flush     (flush),
    .ctl       (ctl),
    .count     (count),
    .count_nxt (count_nxt)
  );

  uart_txb_store #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .wr_data (wr_data),
    .rd_data (tx_data)
  );

  uart_txb_req #(.DEPTH(DEPTH), .CW(CW)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_nxt  (count_nxt),
    .mode       (mode),
    .irq_en     (irq_en),
    .dma_en     (dma_en),
    .tx_req     (tx_req),
    .tx_irq     (tx_irq),
    .tx_dma_req (tx_dma_req)
  );

  assign tx_valid = (count != '0);
  assign tx_empty = (count == '0) && !shift_busy;

  AST_REQ_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TXB_MODE_FIFO) |-> (tx_req == (count <= HALF))); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TXB_MODE_HOLD) |-> (tx_req == !tx_valid)); // R4
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> (!tx_valid && tx_req)); // R3
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> (!tx_valid && tx_req)); // R11
  AST_EMPTY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_busy |-> !tx_empty); // R8
endmodule

// File: tb/sim_uart_tx_buffer.sv
`timescale 1ns/1ps
module sim_uart_tx_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, fifo_mode = 1'b0, fifo_reset = 1'b0;
  logic       irq_en = 1'b0, dma_en = 1'b0, shift_busy = 1'b0, tx_ready = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_valid, tx_req, tx_irq, tx_dma_req, tx_empty;
  logic [7:0] tx_data;

  int nvec = 0, nerr = 0, npops = 0;
  logic [7:0] sb[$];
  int  mcount = 0;
  logic mmode = 1'b0;
  bit  done = 0;

  always #4 clk = ~clk;

  uart_tx_buffer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .fifo_reset(fifo_reset), .irq_en(irq_en),
    .dma_en(dma_en), .shift_busy(shift_busy), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .tx_req(tx_req),
    .tx_irq(tx_irq), .tx_dma_req(tx_dma_req), .tx_empty(tx_empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // monitor and scoreboard: checks the state shown before the coming edge,
  // then advances the reference model by what that edge will do
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic eflag, pop, push;
      int cap;
      eflag = mmode ? (mcount <= 32) : (mcount == 0);
      chk(mmode ? "R2 flag level" : "R4 flag hold", tx_req, eflag);
      chk("R9 valid", tx_valid, mcount != 0);
      chk("R5 irq", tx_irq, eflag && irq_en);
      chk("R6 dma", tx_dma_req, eflag && dma_en && fifo_mode);
      chk("R8 empty", tx_empty, (mcount == 0) && !shift_busy);
      if (fifo_reset || (fifo_mode != mmode)) begin
        sb.delete();
        mcount = 0;
        mmode  = fifo_mode;
      end else begin
        cap  = mmode ? 64 : 1;
        pop  = tx_ready && (mcount != 0);
        push = wr_en && ((mcount < cap) || pop);
        if (pop) begin
          chk("R9 order", tx_data, sb.pop_front());
          npops++;
          mcount--;
        end
        if (push) begin
          sb.push_back(wr_data);
          mcount++;
        end
      end
    end
  end

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int p0;
    logic [15:0] lfsr;
    repeat (3) tick();
    chk("R7 reset req", tx_req, 1);
    chk("R7 reset empty", tx_empty, 1);
    chk("R7 reset valid", tx_valid, 0);
    rst_n = 1'b1;
    tick();

    // FIFO mode, threshold and capacity
    fifo_mode = 1'b1; irq_en = 1'b1; dma_en = 1'b1;
    tick();
    for (int i = 0; i < 32; i++) begin
      wr_en = 1'b1; wr_data = 8'(i + 8'h40); tick();
    end
    wr_en = 1'b0;
    chk("R2 at 32", tx_req, 1);
    wr_en = 1'b1; wr_data = 8'hA0; tick(); wr_en = 1'b0;
    chk("R2 at 33", tx_req, 0);
    for (int i = 0; i < 40; i++) begin
      wr_en = 1'b1; wr_data = 8'(i + 8'h80); shift_busy = i[0]; tick();
    end
    wr_en = 1'b0;
    chk("R1 full valid", tx_valid, 1);
    chk("R1 full dma", tx_dma_req, 0);

    // R10: write and load together while full
    p0 = npops;
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1; wr_data = 8'(8'hE0 + i); tx_ready = 1'b1; tick();
    end
    wr_en = 1'b0;
    for (int i = 0; i < 70; i++) tick();
    tx_ready = 1'b0;
    chk("R1 R10 pops", npops - p0, 67);
    chk("R9 idle ready", tx_valid, 0);

    // R3: flush with concurrent write
    for (int i = 0; i < 10; i++) begin
      wr_en = 1'b1; wr_data = 8'(i); tick();
    end
    fifo_reset = 1'b1; wr_data = 8'h55; tick();
    fifo_reset = 1'b0; wr_en = 1'b0;
    chk("R3 valid", tx_valid, 0);
    chk("R3 req", tx_req, 1);

    // R11: mode change flushes
    for (int i = 0; i < 5; i++) begin
      wr_en = 1'b1; wr_data = 8'(i + 8'h10); tick();
    end
    wr_en = 1'b0; fifo_mode = 1'b0; tick();
    chk("R11 valid", tx_valid, 0);
    chk("R11 req", tx_req, 1);

    // R4: holding register
    wr_en = 1'b1; wr_data = 8'h3C; tick(); wr_en = 1'b0;
    chk("R4 cleared", tx_req, 0);
    chk("R6 hold dma", tx_dma_req, 0);
    wr_en = 1'b1; wr_data = 8'hC3; tick(); wr_en = 1'b0;
    chk("R4 drop valid", tx_valid, 1);
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    chk("R4 set", tx_req, 1);
    chk("R4 second dropped", tx_valid, 0);

    // mixed traffic in both modes
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_en = lfsr[0] | lfsr[1];
      wr_data = lfsr[15:8];
      tx_ready = (i < 1500) ? (lfsr[2] & lfsr[3]) : lfsr[2];
      shift_busy = lfsr[4];
      irq_en = lfsr[5];
      dma_en = lfsr[6];
      fifo_reset = (lfsr[11:7] == 5'h1F);
      if (i == 1000 || i == 2600) fifo_mode = ~fifo_mode;
      tick();
    end
    wr_en = 1'b0; tx_ready = 1'b0; fifo_reset = 1'b0;
    tick();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule